// File: doc/BRIEF.md
# Stereo Capture Word Packer and Memory-Write Arbiter

This block takes two pixel streams, one per image sensor, and writes them into memory through one shared write port. Each stream carries one 32-bit pixel per valid beat, with a frame-start flag on the first pixel of a frame. Each stream can be thinned by a programmable ratio. It is then gathered two pixels at a time into 64-bit words. The words wait in a small FIFO per camera, together with the address each word belongs to.

A round-robin stage picks one camera per transfer and presents a registered request carrying the word, its address and a source tag. The request stays in place until the memory side grants it. Each camera writes into its own buffer, starting at a programmable base address. The address returns to that base at every frame start. A small write-only register port sets the per-camera enables, the thinning ratio and the two base addresses. The typical use is left and right sensor frames of 640x480, with a pixel arriving every fourth system clock.

Top module: `dual_cam_packer`

## Requirements
- R1: After reset, `mem_req` is low, both cameras are disabled, the thinning code is 0 and both bases are 0. Pixels presented in that state produce no transfer.
- R2: A write with `cfg_we` high stores `cfg_wdata` at the selected index. Index 0 is control: bit 0 enables camera 0, bit 1 enables camera 1, and bits [3:2] hold the thinning code d. Index 1 is the camera 0 base and index 2 is the camera 1 base. Index 3 changes nothing.
- R3: With thinning code d, a camera keeps the pixels whose position within the frame is a multiple of d+1. Position 0 is the pixel that carries the frame-start flag with valid.
- R4: Kept pixels are paired in order. The earlier pixel goes in bits [31:0] and the later one in bits [63:32]. Only complete pairs are ever written.
- R5: The first word of a frame goes to that camera's base address, and each later word of the frame goes 8 bytes higher. A frame start discards any unpaired pixel left from before.
- R6: While `mem_req` is high and `mem_gnt` is low, `mem_addr`, `mem_data` and `mem_src` hold their values.
- R7: At most one word is transferred per cycle, on a cycle with `mem_req` and `mem_gnt` both high. `mem_src` is 0 for camera 0 and 1 for camera 1.
- R8: When both cameras have words waiting, the winners alternate. The first tie after reset goes to camera 0.
- R9: A disabled camera's pixels are ignored and it is never selected. With only one camera active and the grant held high, its queued words go out on consecutive cycles.
- R10: Each camera holds up to 5 words (4 in the FIFO and 1 in the output register when it has won). A word completed while its FIFO is full is discarded, but the address still advances past it.
- R11: Words of each camera reach memory in the order they were formed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | 32 | Register write value |
| cam0_sof | input | 1 | Camera 0 frame start, qualified by valid |
| cam0_vld | input | 1 | Camera 0 pixel valid |
| cam0_pix | input | 32 | Camera 0 pixel |
| cam1_sof | input | 1 | Camera 1 frame start, qualified by valid |
| cam1_vld | input | 1 | Camera 1 pixel valid |
| cam1_pix | input | 32 | Camera 1 pixel |
| mem_req | output | 1 | Write request |
| mem_gnt | input | 1 | Write grant; transfer when high with request |
| mem_src | output | 1 | Camera that owns the presented word |
| mem_addr | output | 32 | Byte address of the presented word |
| mem_data | output | 64 | Presented 64-bit word |

## Verification
The arbiter's choice and new words arriving from the two cameras fall in the same cycle, because the sensors are synchronised and both FIFOs fill on the same edge. The bench provokes this in three ways:
- It holds the grant low while both cameras form words, then releases it and checks that the source tags come out as 0, 1, 0, 1.
- It sweeps every thinning code and every enable mix with a grant that drops one cycle in three, then compares each camera's words and addresses with arithmetic predictions.
- It lets a FIFO fill under a stalled grant, so that a completed word is dropped while the output register holds. The bench checks that only the expected words appear and that the next word lands at its own address.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  localparam int NUM_CAMS = 2;

  typedef enum logic [1:0] {
    CFG_CTRL  = 2'd0,
    CFG_BASE0 = 2'd1,
    CFG_BASE1 = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/dcp_cfg_regs.sv
module dcp_cfg_regs #(
  parameter int ADDR_W = 32,
  parameter int DEC_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [1:0]        en,
  output logic [DEC_W-1:0]  ratio,
  output logic [ADDR_W-1:0] base0,
  output logic [ADDR_W-1:0] base1
);
  import dcp_pkg::*;

  cfg_sel_e sel_e;
  assign sel_e = cfg_sel_e'(sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= '0;
      ratio <= '0;
      base0 <= '0;
      base1 <= '0;
    end else if (we) begin
      case (sel_e)
        CFG_CTRL: begin
          en    <= wdata[1:0];
          ratio <= wdata[2 +: DEC_W];
        end
        CFG_BASE0: base0 <= wdata;
        CFG_BASE1: base1 <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dcp_capture_chain.sv
module dcp_capture_chain #(
  parameter int PIX_W  = 32,
  parameter int ADDR_W = 32,
  parameter int DEC_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [DEC_W-1:0]   ratio,
  input  logic [ADDR_W-1:0]  base,
  input  logic               sof,
  input  logic               vld,
  input  logic [PIX_W-1:0]   pix,
  output logic               push,
  output logic [2*PIX_W-1:0] push_word,
  output logic [ADDR_W-1:0]  push_addr
);
  localparam int WORD_W = 2 * PIX_W;
  localparam int STEP   = WORD_W / 8;

  logic [DEC_W-1:0]  skip_q, skip_eff;
  logic              half_q, half_eff;
  logic [PIX_W-1:0]  low_q;
  logic [ADDR_W-1:0] addr_q;
  logic              take, start, keep;

  assign take     = vld & en;
  assign start    = take & sof;
  assign skip_eff = start ? '0 : skip_q;
  assign half_eff = start ? 1'b0 : half_q;
  assign keep     = take && (skip_eff == '0);

  assign push      = keep && half_eff;
  assign push_word = {pix, low_q};
  assign push_addr = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_q <= '0;
      half_q <= 1'b0;
      low_q  <= '0;
      addr_q <= '0;
    end else begin
      if (take)
        skip_q <= (skip_eff == ratio) ? '0 : skip_eff + 1'b1;
      if (keep)
        half_q <= ~half_eff;
      if (keep && !half_eff)
        low_q <= pix;
      if (start)
        addr_q <= base;
      else if (push)
        addr_q <= addr_q + ADDR_W'(STEP);
    end
  end
endmodule

// File: rtl/dcp_sync_fifo.sv
module dcp_sync_fifo #(
  parameter int W     = 96,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          full, do_wr, do_rd;

  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr)
      mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr)
        wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_rd)
        rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dcp_rr_port.sv
module dcp_rr_port #(
  parameter int WORD_W = 64,
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             req,
  input  logic [1:0][WORD_W-1:0] head_data,
  input  logic [1:0][ADDR_W-1:0] head_addr,
  input  logic                   mem_gnt,
  output logic [1:0]             pop,
  output logic                   mem_req,
  output logic                   mem_src,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [WORD_W-1:0]      mem_data
);
  logic prio_q, pick, load, any;

  assign load = !mem_req || mem_gnt;
  assign any  = |req;
  assign pick = (req == 2'b11) ? prio_q : req[1];
  assign pop  = (load && any) ? (pick ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q   <= 1'b0;
      mem_req  <= 1'b0;
      mem_src  <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else if (load) begin
      mem_req <= any;
      if (any) begin
        prio_q   <= ~pick;
        mem_src  <= pick;
        mem_addr <= head_addr[pick];
        mem_data <= head_data[pick];
      end
    end
  end
endmodule

// File: rtl/dual_cam_packer.sv
module dual_cam_packer #(
  parameter int PIX_W      = 32,
  parameter int ADDR_W     = 32,
  parameter int DEC_W      = 2,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_addr,
  input  logic [ADDR_W-1:0]   cfg_wdata,
  input  logic                cam0_sof,
  input  logic                cam0_vld,
  input  logic [PIX_W-1:0]    cam0_pix,
  input  logic                cam1_sof,
  input  logic                cam1_vld,
  input  logic [PIX_W-1:0]    cam1_pix,
  output logic                mem_req,
  input  logic                mem_gnt,
  output logic                mem_src,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*PIX_W-1:0]  mem_data
);
  import dcp_pkg::*;

  localparam int WORD_W = 2 * PIX_W;
  localparam int ENT_W  = WORD_W + ADDR_W;

  logic [NUM_CAMS-1:0]             cam_en, chain_req, chain_pop;
  logic [DEC_W-1:0]                ratio;
  logic [NUM_CAMS-1:0][ADDR_W-1:0] base_a, paddr_a, head_addr;
  logic [NUM_CAMS-1:0]             sof_a, vld_a, push_a, empty_a;
  logic [NUM_CAMS-1:0][PIX_W-1:0]  pix_a;
  logic [NUM_CAMS-1:0][WORD_W-1:0] pword_a, head_data;
  logic [NUM_CAMS-1:0][ENT_W-1:0]  head_a;

  assign sof_a = {cam1_sof, cam0_sof};
  assign vld_a = {cam1_vld, cam0_vld};
  assign pix_a[0] = cam0_pix;
  assign pix_a[1] = cam1_pix;

  dcp_cfg_regs #(.ADDR_W(ADDR_W), .DEC_W(DEC_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_addr), .wdata(cfg_wdata),
    .en(cam_en), .ratio(ratio), .base0(base_a[0]), .base1(base_a[1])
  );

  for (genvar g = 0; g < NUM_CAMS; g++) begin : g_chain
    dcp_capture_chain #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .DEC_W(DEC_W)) u_chain (
      .clk(clk), .rst(rst), .en(cam_en[g]), .ratio(ratio), .base(base_a[g]),
      .sof(sof_a[g]), .vld(vld_a[g]), .pix(pix_a[g]),
      .push(push_a[g]), .push_word(pword_a[g]), .push_addr(paddr_a[g])
    );

    dcp_sync_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .wr(push_a[g]), .wdata({paddr_a[g], pword_a[g]}),
      .rd(chain_pop[g]), .rdata(head_a[g]), .empty(empty_a[g])
    );

    assign chain_req[g] = cam_en[g] & ~empty_a[g];
    assign head_data[g] = head_a[g][WORD_W-1:0];
    assign head_addr[g] = head_a[g][ENT_W-1:WORD_W];
  end

  dcp_rr_port #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst), .req(chain_req), .head_data(head_data),
    .head_addr(head_addr), .mem_gnt(mem_gnt), .pop(chain_pop),
    .mem_req(mem_req), .mem_src(mem_src), .mem_addr(mem_addr), .mem_data(mem_data)
  );
endmodule

// File: rtl/dcp_checker.sv
module dcp_checker #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        en,
  input logic [1:0]        req,
  input logic [1:0]        pop,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic              mem_src,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_data
);
  logic [1:0] en_d;
  always_ff @(posedge clk) begin
    if (rst) en_d <= '0;
    else     en_d <= en;
  end

  AST_HOLD_UNTIL_GNT: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_data) && $stable(mem_src))); // R6

  AST_SINGLE_POP: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pop)); // R7

  AST_ENABLED_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !$past(mem_req && !mem_gnt)) |-> en_d[mem_src]); // R9

  AST_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_gnt && req == 2'b11) |=> (mem_req && (mem_src != $past(mem_src)))); // R8
endmodule

bind dual_cam_packer dcp_checker #(.ADDR_W(ADDR_W), .WORD_W(2*PIX_W)) i_chk (
  .clk(clk), .rst(rst), .en(cam_en), .req(chain_req), .pop(chain_pop),
  .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_src(mem_src),
  .mem_addr(mem_addr), .mem_data(mem_data)
);

// File: tb/test_dual_cam_packer.sv
module test_dual_cam_packer;
  localparam int CLK_PERIOD = 10;
  localparam int MAXREC = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cam0_sof = 0, cam0_vld = 0, cam1_sof = 0, cam1_vld = 0;
  logic [31:0] cam0_pix = '0, cam1_pix = '0;
  logic        mem_req, mem_src, mem_gnt;
  logic [31:0] mem_addr;
  logic [63:0] mem_data;
  logic        gnt_auto = 1'b0, gnt_man = 1'b0;
  int          cyc = 0;

  int n_chk = 0, n_fail = 0;
  int rec_n = 0;
  logic        rec_src  [MAXREC];
  logic [31:0] rec_addr [MAXREC];
  logic [63:0] rec_data [MAXREC];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign mem_gnt = gnt_auto ? ((cyc % 3) != 2) : gnt_man;

  dual_cam_packer i_dual_cam_packer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cam0_sof(cam0_sof), .cam0_vld(cam0_vld), .cam0_pix(cam0_pix),
    .cam1_sof(cam1_sof), .cam1_vld(cam1_vld), .cam1_pix(cam1_pix),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_src(mem_src),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  always @(negedge clk) begin
    if (!rst && mem_req && mem_gnt && rec_n < MAXREC) begin
      rec_src[rec_n]  = mem_src;
      rec_addr[rec_n] = mem_addr;
      rec_data[rec_n] = mem_data;
      rec_n++;
    end
  end

  function automatic logic [31:0] px(input int c, input int f, input int i);
    return {8'h5A, (c == 1) ? 8'hC1 : 8'hC0, 8'(f), 8'(i)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic send_seq(input int first, input int npix, input int gap, input int f, input bit with_sof);
    for (int i = 0; i < npix; i++) begin
      @(posedge clk); #1;
      cam0_vld = 1'b1; cam1_vld = 1'b1;
      cam0_sof = with_sof && (i == 0); cam1_sof = with_sof && (i == 0);
      cam0_pix = px(0, f, first + i); cam1_pix = px(1, f, first + i);
      if (gap > 1) begin
        @(posedge clk); #1;
        cam0_vld = 1'b0; cam1_vld = 1'b0; cam0_sof = 1'b0; cam1_sof = 1'b0;
        repeat (gap - 2) @(posedge clk);
      end
    end
    @(posedge clk); #1;
    cam0_vld = 1'b0; cam1_vld = 1'b0; cam0_sof = 1'b0; cam1_sof = 1'b0;
  endtask

  // Expected words of one camera for a frame: kept positions are multiples of N=d+1,
  // word j pairs kept pixels 2j (low) and 2j+1 (high), at base + 8j.
  task automatic compare_cam(input int c, input int start, input int d, input int npix,
                             input int f, input logic [31:0] base, input bit enabled);
    int nn, n_exp, j;
    logic [63:0] ed;
    nn = d + 1;
    n_exp = enabled ? (((npix + d) / nn) / 2) : 0;
    j = 0;
    for (int r = start; r < rec_n; r++) begin
      if (rec_src[r] == c[0]) begin
        if (j < n_exp) begin
          ed = {px(c, f, (2*j+1)*nn), px(c, f, 2*j*nn)};
          chk(rec_data[r] == ed, "R3 R4 R11 word data", rec_data[r], ed);
          chk(rec_addr[r] == base + 32'(8*j), "R5 word address", 64'(rec_addr[r]), 64'(base + 32'(8*j)));
        end
        j++;
      end
    end
    chk(j == n_exp, "R9 R3 word count per camera", 64'(j), 64'(n_exp));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int start, fid;
    logic [31:0] b0, b1;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1: idle after reset, and pixels are ignored while both cameras start disabled
    @(negedge clk);
    chk(mem_req == 1'b0, "R1 request low after reset", 64'(mem_req), 64'd0);
    gnt_man = 1'b1;
    start = rec_n;
    send_seq(0, 6, 1, 0, 1'b1);
    repeat (8) @(posedge clk);
    chk(rec_n == start, "R1 R9 disabled at reset, no transfer", 64'(rec_n - start), 64'd0);
    gnt_man = 1'b0;

    // R8: first tie after reset goes to camera 0, then strict alternation
    b0 = 32'h1000_0000; b1 = 32'h2000_0000;
    cfg_write(2'd1, b0);
    cfg_write(2'd2, b1);
    cfg_write(2'd0, 32'h3);
    start = rec_n;
    send_seq(0, 4, 1, 1, 1'b1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(mem_req && mem_src == 1'b0, "R8 first tie to camera 0", {mem_req, mem_src}, 64'b10);
    @(posedge clk); #1 gnt_man = 1'b1;
    repeat (10) @(posedge clk);
    chk(rec_n - start == 4, "R7 R8 transfer count", 64'(rec_n - start), 64'd4);
    for (int k = 0; k < 4; k++)
      chk(rec_src[start + k] == k[0], "R8 alternating source", 64'(rec_src[start + k]), 64'(k[0]));
    compare_cam(0, start, 0, 4, 1, b0, 1'b1);
    compare_cam(1, start, 0, 4, 1, b1, 1'b1);

    // R6, R9: only camera 0 enabled; held request then back-to-back burst
    gnt_man = 1'b0;
    cfg_write(2'd0, 32'h1);
    start = rec_n;
    send_seq(0, 6, 1, 2, 1'b1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(mem_req && mem_addr == b0, "R6 request holds first word", 64'(mem_addr), 64'(b0));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_req && mem_addr == b0 && mem_data == {px(0,2,1), px(0,2,0)},
        "R6 stalled word stable", mem_data, {px(0,2,1), px(0,2,0)});
    @(posedge clk); #1 gnt_man = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(mem_req && mem_gnt && mem_src == 1'b0, "R9 back-to-back single camera",
          {mem_req, mem_gnt, mem_src}, 64'b110);
    end
    @(negedge clk);
    chk(mem_req == 1'b0, "R9 burst ends after queued words", 64'(mem_req), 64'd0);
    compare_cam(0, start, 0, 6, 2, b0, 1'b1);
    compare_cam(1, start, 0, 6, 2, b1, 1'b0);

    // R10: overflow under a stalled grant; dropped words keep their address slots
    gnt_man = 1'b0;
    start = rec_n;
    send_seq(0, 14, 1, 3, 1'b1);
    repeat (5) @(posedge clk);
    @(posedge clk); #1 gnt_man = 1'b1;
    repeat (10) @(posedge clk);
    chk(rec_n - start == 5, "R10 five words survive the stall", 64'(rec_n - start), 64'd5);
    send_seq(14, 2, 1, 3, 1'b0);
    repeat (10) @(posedge clk);
    chk(rec_n - start == 6, "R10 one more word after drain", 64'(rec_n - start), 64'd6);
    for (int k = 0; k < 5; k++) begin
      chk(rec_data[start+k] == {px(0,3,2*k+1), px(0,3,2*k)}, "R10 R11 kept word data",
          rec_data[start+k], {px(0,3,2*k+1), px(0,3,2*k)});
      chk(rec_addr[start+k] == b0 + 32'(8*k), "R10 kept word address",
          64'(rec_addr[start+k]), 64'(b0 + 32'(8*k)));
    end
    chk(rec_addr[start+5] == b0 + 32'd56, "R10 address advanced past dropped words",
        64'(rec_addr[start+5]), 64'(b0 + 32'd56));
    chk(rec_data[start+5] == {px(0,3,15), px(0,3,14)}, "R10 word after drop",
        rec_data[start+5], {px(0,3,15), px(0,3,14)});

    // R2, R3, R5, R7: sweep thinning codes, enable mixes and frame lengths under a gappy grant
    gnt_man = 1'b0;
    gnt_auto = 1'b1;
    fid = 10;
    for (int d = 0; d < 4; d++) begin
      for (int em = 1; em < 4; em++) begin
        for (int l = 0; l < 2; l++) begin
          b0 = 32'h4000_0000 + 32'(d * 32'h100) + 32'(em * 32'h10000);
          b1 = 32'h8000_0000 + 32'(d * 32'h200) + 32'(em * 32'h20000);
          cfg_write(2'd1, b0);
          cfg_write(2'd2, b1);
          cfg_write(2'd3, 32'hFFFF_FFFF);
          cfg_write(2'd0, 32'(d << 2) | 32'(em));
          start = rec_n;
          send_seq(0, (l == 0) ? 8 : 13, (l == 0) ? 4 : 1, fid, 1'b1);
          repeat (30) @(posedge clk);
          compare_cam(0, start, d, (l == 0) ? 8 : 13, fid, b0, em[0]);
          compare_cam(1, start, d, (l == 0) ? 8 : 13, fid, b1, em[1]);
          fid++;
        end
      end
    end

    finish_run();
  end
endmodule